// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter with Sample Queue

This block turns PCM samples into a two-channel serial audio stream. Samples arrive on a plain write port and wait in a small queue. Each stereo frame lasts 64 bit-clock periods and is split into a left slot of 32 bits and a right slot of 32 bits. A sample is placed at the top of its slot, sent most significant bit first, and followed by zeros. The block sources the bit clock and the word clock, or follows external ones. Each of the two clocks is chosen on its own.

A DMA request is raised while playback runs and the queue holds no more words than a threshold input. Playback needs both the interface enable and the playback enable. A one-cycle flush strobe empties the queue. When a slot starts and the queue is empty, the block sends silence, or repeats the last sample if asked to, and raises a sticky underrun flag. The rate of the bit clock comes from a half-period tick supplied from outside.

Top module: `i2s_tx_serializer`

## Requirements
- R1: When the block drives the word clock, the line is low for the 32 bit-clock periods of the left slot and high for the 32 periods of the right slot. As bit-clock master, it changes only on a falling bit-clock edge.
- R2: `size_code` sets the sample width: 0 is 8 bits, 1 is 16 bits, 3 is 20 bits, and any other code is 24 bits. The width is taken from the low bits of the queue word, sent MSB first, and the rest of the 32-bit slot is zeros.
- R3: With `mono` set, each queued sample is sent in both the left slot and the right slot of one frame, and only one queue word is used per frame.
- R4: With `msb_just` clear, the sample MSB comes one bit-clock period after the word-clock edge. With it set, the MSB is sent in the bit period that starts at the word-clock edge. Data changes on falling bit-clock edges.
- R5: With `bclk_master` set, `bclk_oe` is high and `bclk_o` toggles on every `half_tick` while `glb_en` is set. With it clear, `bclk_oe` is low and the block times itself from `bclk_in`.
- R6: With `ws_master` clear, `ws_oe` is low and the slot position locks to edges on `ws_in`, sampled on rising bit-clock edges. Low on `ws_in` marks the left slot.
- R7: `dma_req` is high exactly when `glb_en` and `play_en` are both set and the queue fill is at or below `dma_thr`.
- R8: A one-cycle `flush` empties the queue. Words written before the flush are never sent.
- R9: While `glb_en` or `play_en` is clear, no word leaves the queue, slots carry zeros, and the underrun flag does not change.
- R10: A slot that starts while playing with an empty queue is sent as zeros and sets `underrun`. The flag holds until `urun_clr`.
- R11: With `urun_repeat` set, a starved slot carries the last sample taken from the queue instead of zeros.
- R12: The queue holds `DEPTH` words. `fifo_full` is high when it is full, and a write while full is dropped.
- R13: After playback is enabled, the first queued sample goes out in a left slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_tick | input | 1 | One pulse per half bit-clock period (used as master) |
| glb_en | input | 1 | Interface enable |
| play_en | input | 1 | Playback enable |
| bclk_master | input | 1 | 1: drive the bit clock, 0: follow `bclk_in` |
| ws_master | input | 1 | 1: drive the word clock, 0: follow `ws_in` |
| msb_just | input | 1 | 0: I2S framing, 1: MSB-justified framing |
| mono | input | 1 | Send each sample in both slots |
| size_code | input | 3 | Sample width code |
| urun_repeat | input | 1 | Repeat last sample on starvation |
| urun_clr | input | 1 | Clear the underrun flag |
| flush | input | 1 | Empty the queue |
| dma_thr | input | LW | DMA request fill threshold |
| wr_en | input | 1 | Queue write strobe |
| wr_data | input | 32 | Queue write word, sample right-aligned |
| fifo_full | output | 1 | Queue is full |
| dma_req | output | 1 | DMA request |
| underrun | output | 1 | Sticky starvation flag |
| bclk_in | input | 1 | External bit clock |
| ws_in | input | 1 | External word clock |
| bclk_o | output | 1 | Generated bit clock |
| bclk_oe | output | 1 | Bit-clock output enable |
| ws_o | output | 1 | Generated word clock |
| ws_oe | output | 1 | Word-clock output enable |
| sd_o | output | 1 | Serial data |

## Verification
The properties assume that external clocks are slow compared to `clk`. They expect each half period of `bclk_in` to last several system cycles and `ws_in` to change only just after a falling bit-clock edge. They also assume `half_tick` pulses are at least a few cycles apart, that `flush` is a single-cycle strobe, and that mode inputs change only while the block is held in reset. The stimulus follows these rules: it pulses the tick every fourth cycle, gives the external bit clock a half period of six cycles, and moves the external word clock from the same step that lowers the bit clock. All configuration is applied during a reset, and playback starts only after two full frames of running clocks.

// File: rtl/i2s_tx_serializer.sv
module i2s_tx_serializer #(
  parameter int DEPTH = 32,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          half_tick,
  input  logic          glb_en,
  input  logic          play_en,
  input  logic          bclk_master,
  input  logic          ws_master,
  input  logic          msb_just,
  input  logic          mono,
  input  logic [2:0]    size_code,
  input  logic          urun_repeat,
  input  logic          urun_clr,
  input  logic          flush,
  input  logic [LW-1:0] dma_thr,
  input  logic          wr_en,
  input  logic [31:0]   wr_data,
  output logic          fifo_full,
  output logic          dma_req,
  output logic          underrun,
  input  logic          bclk_in,
  input  logic          ws_in,
  output logic          bclk_o,
  output logic          bclk_oe,
  output logic          ws_o,
  output logic          ws_oe,
  output logic          sd_o
);
  localparam int AW = $clog2(DEPTH);

  logic [31:0]   mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [LW-1:0] level;
  logic          b1, b2, b3, w1, w2;
  logic          bclk_q, ws_q, sd_q, ws_cap, ws_last, active;
  logic [5:0]    cnt;
  logic [31:0]   word_q, last_w, aligned, nw;

  wire run   = glb_en & play_en;
  wire empty = (level == '0);
  assign fifo_full = (level == LW'(DEPTH));
  wire push  = wr_en & ~fifo_full & ~flush;

  wire fall = bclk_master ? (glb_en & half_tick & bclk_q)  : (b3 & ~b2);
  wire rise = bclk_master ? (glb_en & half_tick & ~bclk_q) : (~b3 & b2);

  wire [5:0] exp_pos = cnt + 6'd1;
  wire       resync  = ~ws_master & (ws_cap != ws_last) & (exp_pos != {ws_cap, 5'd1});
  wire [5:0] pos_n   = resync ? {ws_cap, 5'd1} : exp_pos;
  wire       right   = pos_n[5];
  wire       load    = fall & (resync | (pos_n[4:0] == 5'd0));
  wire       dup     = mono & right;
  wire       take    = run & (~right | active);
  wire       pop     = load & take & ~dup & ~empty;
  wire       starve  = load & take & ~dup & empty;

  wire [31:0] head = mem[rptr];

  always_comb begin
    case (size_code)
      3'd0:    aligned = {head[7:0],  24'd0};
      3'd1:    aligned = {head[15:0], 16'd0};
      3'd3:    aligned = {head[19:0], 12'd0};
      default: aligned = {head[23:0], 8'd0};
    endcase
  end

  always_comb begin
    if (!take)      nw = '0;
    else if (dup)   nw = word_q;
    else if (!empty) nw = aligned;
    else            nw = urun_repeat ? last_w : '0;
  end

  wire [31:0] cur = load ? nw : word_q;
  wire [5:0]  idx = msb_just ? (6'd31 - {1'b0, pos_n[4:0]}) : (6'd32 - {1'b0, pos_n[4:0]});
  wire        sd_n = idx[5] ? 1'b0 : cur[idx[4:0]];

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0; rptr <= '0; level <= '0;
      b1 <= 1'b0; b2 <= 1'b0; b3 <= 1'b0; w1 <= 1'b0; w2 <= 1'b0;
      bclk_q <= 1'b0; ws_q <= 1'b0; sd_q <= 1'b0;
      ws_cap <= 1'b0; ws_last <= 1'b0; active <= 1'b0;
      cnt <= 6'h3F; word_q <= '0; last_w <= '0; underrun <= 1'b0;
    end else begin
      b1 <= bclk_in; b2 <= b1; b3 <= b2;
      w1 <= ws_in;   w2 <= w1;
      if (!glb_en) bclk_q <= 1'b0;
      else if (half_tick) bclk_q <= ~bclk_q;
      if (rise) ws_cap <= w2;
      if (fall) begin
        cnt     <= pos_n;
        ws_last <= ws_cap;
        sd_q    <= sd_n;
        if (ws_master) ws_q <= pos_n[5];
      end
      if (load) begin
        word_q <= nw;
        if (!right) active <= run;
      end
      if (pop) last_w <= aligned;
      if (starve) underrun <= 1'b1;
      else if (urun_clr) underrun <= 1'b0;
      if (flush) begin
        wptr <= '0; rptr <= '0; level <= '0;
      end else begin
        if (push) wptr <= wptr + 1'b1;
        if (pop)  rptr <= rptr + 1'b1;
        level <= level + LW'(push) - LW'(pop);
      end
    end
  end

  assign dma_req = run & (level <= dma_thr);
  assign bclk_o  = bclk_q;
  assign bclk_oe = bclk_master;
  assign ws_o    = ws_q;
  assign ws_oe   = ws_master;
  assign sd_o    = sd_q;
endmodule

// File: rtl/i2s_tx_chk.sv
module i2s_tx_chk #(
  parameter int DEPTH = 32,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          half_tick,
  input logic          glb_en,
  input logic          play_en,
  input logic          bclk_master,
  input logic          ws_master,
  input logic          flush,
  input logic          urun_clr,
  input logic          dma_req,
  input logic          underrun,
  input logic          bclk_o,
  input logic          ws_o,
  input logic [LW-1:0] level
);
  p_req_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(glb_en && play_en) |-> !dma_req);

  p_urun_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    underrun && !urun_clr |=> underrun);

  p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));

  p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> level == '0);

  p_bclk_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_master && glb_en && half_tick |=> !$stable(bclk_o));

  p_ws_on_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ws_master && bclk_master && !$stable(ws_o) |-> $fell(bclk_o));
endmodule

bind i2s_tx_serializer i2s_tx_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .glb_en(glb_en),
  .play_en(play_en), .bclk_master(bclk_master), .ws_master(ws_master),
  .flush(flush), .urun_clr(urun_clr), .dma_req(dma_req), .underrun(underrun),
  .bclk_o(bclk_o), .ws_o(ws_o), .level(level)
);

// File: tb/sim_i2s_tx_serializer.sv
module sim_i2s_tx_serializer;
  localparam int DEPTH = 32;
  localparam int LW = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0, half_tick = 0, glb_en = 0, play_en = 0;
  logic bclk_master = 1, ws_master = 1, msb_just = 0, mono = 0;
  logic urun_repeat = 0, urun_clr = 0, flush = 0, wr_en = 0, bclk_in = 0, ws_in = 0;
  logic [2:0] size_code = 3'd1;
  logic [LW-1:0] dma_thr = LW'(8);
  logic [31:0] wr_data = '0;
  wire fifo_full, dma_req, underrun, bclk_o, bclk_oe, ws_o, ws_oe, sd_o;

  int checks = 0, errors = 0;
  logic [31:0] cap_w [256];
  logic        cap_r [256];
  int ncap = 0;
  int half_len = 0;
  logic [31:0] exp_w [64];

  i2s_tx_serializer #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .glb_en(glb_en), .play_en(play_en),
    .bclk_master(bclk_master), .ws_master(ws_master), .msb_just(msb_just), .mono(mono),
    .size_code(size_code), .urun_repeat(urun_repeat), .urun_clr(urun_clr), .flush(flush),
    .dma_thr(dma_thr), .wr_en(wr_en), .wr_data(wr_data), .fifo_full(fifo_full),
    .dma_req(dma_req), .underrun(underrun), .bclk_in(bclk_in), .ws_in(ws_in),
    .bclk_o(bclk_o), .bclk_oe(bclk_oe), .ws_o(ws_o), .ws_oe(ws_oe), .sd_o(sd_o)
  );

  always #10 clk = ~clk;

  initial begin : line_proc
    int tcnt, scnt, bc, hl, bp;
    logic pline, pws, line, wl, sws;
    logic [31:0] w;
    tcnt = 0; scnt = 0; bc = 0; hl = 0; bp = 99;
    pline = 0; pws = 0; sws = 0; w = '0;
    forever begin
      @(negedge clk);
      tcnt++;
      half_tick = (tcnt % 4 == 0);
      if (!rst_n) begin
        scnt = 0; bc = 0; bclk_in = 0; ws_in = 0; pline = 0; pws = 0;
        bp = 99; hl = 0; ncap = 0; half_len = 0;
      end else begin
        if (!bclk_master) begin
          scnt++;
          if (scnt == 6) begin scnt = 0; bclk_in = ~bclk_in; end
        end
        line = bclk_master ? bclk_o : bclk_in;
        wl = ws_master ? ws_o : ws_in;
        if (line && !pline) begin
          if (wl != pws) begin if (hl > 0) half_len = hl; hl = 1; end
          else hl++;
          if (msb_just && wl != pws) begin bp = 0; sws = wl; end
          if (bp >= 0 && bp < 32) begin
            w[31-bp] = sd_o;
            bp++;
            if (bp == 32 && ncap < 256) begin cap_w[ncap] = w; cap_r[ncap] = sws; ncap++; end
          end
          if (!msb_just && wl != pws) begin bp = 0; sws = wl; end
          pws = wl;
        end
        if (!line && pline) begin
          bc++;
          ws_in = ((bc >> 5) & 1) != 0;
        end
        pline = line;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  function automatic logic [31:0] al(input logic [31:0] s, input logic [2:0] c);
    case (c)
      3'd0:    return {s[7:0], 24'd0};
      3'd1:    return {s[15:0], 16'd0};
      3'd3:    return {s[19:0], 12'd0};
      default: return {s[23:0], 8'd0};
    endcase
  endfunction

  task automatic wait_frames(input int n);
    repeat (n * 64 * (bclk_master ? 8 : 12)) @(negedge clk);
  endtask

  task automatic start(input bit bm, input bit wm, input bit msb, input bit mn, input logic [2:0] code);
    @(negedge clk);
    rst_n = 0; glb_en = 0; play_en = 0; bclk_master = bm; ws_master = wm;
    msb_just = msb; mono = mn; size_code = code; urun_repeat = 0; urun_clr = 0;
    flush = 0; wr_en = 0; dma_thr = LW'(8);
    repeat (3) @(negedge clk);
    rst_n = 1; glb_en = 1;
    wait_frames(2);
  endtask

  task automatic push(input logic [31:0] v);
    @(negedge clk); wr_en = 1; wr_data = v;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic cmp(input string req, input int n);
    int first;
    bit ok;
    logic [31:0] a, e;
    first = -1; ok = 1; a = '0; e = '0;
    for (int i = 0; i < ncap; i++) if (first < 0 && cap_w[i] != 0) first = i;
    if (first < 0 || first + n > ncap) ok = 0;
    else begin
      if (cap_r[first] != 1'b0) ok = 0;
      for (int k = 0; k < n; k++)
        if (ok && cap_w[first+k] !== exp_w[k]) begin ok = 0; a = cap_w[first+k]; e = exp_w[k]; end
    end
    chk(ok, req, "slot stream", a, e);
  endtask

  task automatic t_reset;
    start(1, 1, 0, 0, 3'd1);
    chk(sd_o == 0 && ws_oe == 1, "R5", "reset sd/ws_oe", {30'd0, sd_o, ws_oe}, 32'd1);
    chk(bclk_oe == 1, "R5", "bclk_oe master", {31'd0, bclk_oe}, 32'd1);
    chk(dma_req == 0, "R7", "reset dma_req", {31'd0, dma_req}, 32'd0);
    chk(underrun == 0, "R10", "reset underrun", {31'd0, underrun}, 32'd0);
    chk(fifo_full == 0, "R12", "reset full", {31'd0, fifo_full}, 32'd0);
  endtask

  task automatic t_stereo16;
    logic [31:0] s;
    start(1, 1, 0, 0, 3'd1);
    for (int i = 0; i < 6; i++) begin
      s = 32'h5A5A_0000 | (32'h1234 + 32'h0101 * i);
      exp_w[i] = al(s, 3'd1);
      push(s);
    end
    play_en = 1; wait_frames(5); play_en = 0;
    cmp("R2 R4 R13 i2s 16-bit", 6);
    chk(half_len == 32, "R1", "ws half length", half_len, 32);
  endtask

  task automatic t_msb24;
    logic [31:0] s;
    start(0, 1, 1, 0, 3'd4);
    chk(bclk_oe == 0, "R5", "bclk_oe slave", {31'd0, bclk_oe}, 32'd0);
    for (int i = 0; i < 4; i++) begin
      s = 32'hC3_800001 + 32'h0011_2233 * i;
      exp_w[i] = al(s, 3'd4);
      push(s);
    end
    play_en = 1; wait_frames(4); play_en = 0;
    cmp("R4 R5 msb 24-bit", 4);
    chk(half_len == 32, "R1", "ws half length slave bclk", half_len, 32);
  endtask

  task automatic t_mono8;
    logic [31:0] s;
    start(1, 0, 0, 1, 3'd0);
    chk(ws_oe == 0, "R6", "ws_oe slave", {31'd0, ws_oe}, 32'd0);
    for (int i = 0; i < 3; i++) begin
      s = 32'hFFFF_FF81 + 32'h13 * i;
      exp_w[2*i] = al(s, 3'd0);
      exp_w[2*i+1] = al(s, 3'd0);
      push(s);
    end
    play_en = 1; wait_frames(5); play_en = 0;
    cmp("R3 R6 mono 8-bit", 6);
  endtask

  task automatic t_slave20;
    logic [31:0] s;
    start(0, 0, 0, 0, 3'd3);
    for (int i = 0; i < 4; i++) begin
      s = 32'hABC8_0001 + 32'h0003_1111 * i;
      exp_w[i] = al(s, 3'd3);
      push(s);
    end
    play_en = 1; wait_frames(4); play_en = 0;
    cmp("R2 R6 both slave 20-bit", 4);
  endtask

  task automatic t_reserved;
    logic [31:0] s;
    start(1, 1, 1, 0, 3'd2);
    for (int i = 0; i < 2; i++) begin
      s = 32'h7E_9ABCDE - i;
      exp_w[i] = al(s, 3'd4);
      push(s);
    end
    play_en = 1; wait_frames(3); play_en = 0;
    cmp("R2 reserved code as 24-bit", 2);
  endtask

  task automatic t_underrun(input bit rep);
    logic [31:0] s0, s1;
    start(1, 1, 0, 0, 3'd1);
    urun_repeat = rep;
    s0 = 32'h0000_8421; s1 = 32'h0000_1357;
    push(s0); push(s1);
    exp_w[0] = al(s0, 3'd1); exp_w[1] = al(s1, 3'd1);
    for (int k = 2; k < 6; k++) exp_w[k] = rep ? al(s1, 3'd1) : 32'd0;
    play_en = 1; wait_frames(5); play_en = 0;
    if (rep) cmp("R11 repeat last", 6);
    else begin
      cmp("R10 zeros on starve", 6);
      chk(underrun == 1, "R10", "flag set", {31'd0, underrun}, 32'd1);
      wait_frames(1);
      chk(underrun == 1, "R10", "flag sticky", {31'd0, underrun}, 32'd1);
      @(negedge clk); urun_clr = 1; @(negedge clk); urun_clr = 0; @(negedge clk);
      chk(underrun == 0, "R10", "flag cleared", {31'd0, underrun}, 32'd0);
    end
  endtask

  task automatic t_dma;
    start(1, 1, 0, 0, 3'd1);
    for (int i = 0; i < 10; i++) push(32'h100 + i);
    @(negedge clk);
    chk(dma_req == 0, "R9", "no request while stopped", {31'd0, dma_req}, 32'd0);
    play_en = 1; @(negedge clk);
    chk(dma_req == 0, "R7", "fill above threshold", {31'd0, dma_req}, 32'd0);
    dma_thr = LW'(12); @(negedge clk);
    chk(dma_req == 1, "R7", "fill at or below threshold", {31'd0, dma_req}, 32'd1);
    play_en = 0; @(negedge clk);
    chk(dma_req == 0, "R7", "playback disabled", {31'd0, dma_req}, 32'd0);
  endtask

  task automatic t_flush;
    start(1, 1, 0, 0, 3'd1);
    for (int i = 0; i < 5; i++) push(32'h7700 + i);
    @(negedge clk); flush = 1; @(negedge clk); flush = 0;
    dma_thr = '0; play_en = 1; @(negedge clk);
    chk(dma_req == 1, "R8", "fill zero after flush", {31'd0, dma_req}, 32'd1);
    play_en = 0;
    push(32'h0000_0E01); push(32'h0000_0E02);
    exp_w[0] = al(32'h0E01, 3'd1); exp_w[1] = al(32'h0E02, 3'd1);
    play_en = 1; wait_frames(3); play_en = 0;
    cmp("R8 flushed words not sent", 2);
  endtask

  task automatic t_full;
    logic [31:0] s;
    start(1, 1, 0, 0, 3'd1);
    for (int i = 0; i < DEPTH + 1; i++) begin
      s = 32'h0000_2000 + i;
      if (i < DEPTH) exp_w[i] = al(s, 3'd1);
      push(s);
    end
    exp_w[DEPTH] = 32'd0;
    chk(fifo_full == 1, "R12", "full flag", {31'd0, fifo_full}, 32'd1);
    play_en = 1; wait_frames(DEPTH / 2 + 3); play_en = 0;
    cmp("R12 write while full dropped", DEPTH + 1);
  endtask

  task automatic t_gate;
    bit allz;
    start(1, 1, 0, 0, 3'd1);
    push(32'h0000_4444); push(32'h0000_5555);
    exp_w[0] = al(32'h4444, 3'd1); exp_w[1] = al(32'h5555, 3'd1);
    wait_frames(2);
    allz = (ncap > 0);
    for (int i = 0; i < ncap; i++) if (cap_w[i] != 0) allz = 0;
    chk(allz, "R9", "zero slots while stopped", ncap, 32'd0);
    chk(underrun == 0, "R9", "no underrun while stopped", {31'd0, underrun}, 32'd0);
    play_en = 1; wait_frames(3); play_en = 0;
    cmp("R9 R13 nothing popped while stopped", 2);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    t_reset;
    t_stereo16;
    t_msb24;
    t_mono8;
    t_slave20;
    t_reserved;
    t_underrun(0);
    t_underrun(1);
    t_dma;
    t_flush;
    t_full;
    t_gate;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule